// File: doc/BRIEF.md
# Fused Intensity and Census Stereo Matching Cost

This block scores how well one pixel of the reference view of a rectified stereo pair matches each of a series of candidate pixels in the other view, one candidate per clock. Each candidate carries two pixel intensities and two census signatures. The first signature belongs to the reference pixel and the second to the candidate. The block takes the magnitude of the intensity difference and the number of signature bits that disagree. It scales each measure to a common fixed-point range by dividing it by its largest possible value, then adds the two. The sum is then clamped to a ceiling that is supplied at run time. A disparity selector downstream consumes the costs.

Candidates stream in back to back or with gaps. The block tags every accepted candidate with its position inside the group of disparities that belongs to one reference pixel. It also flags the final position of each group, so the consumer can find group boundaries without keeping a count of its own. The datapath has four register stages. A valid flag travels with the data through every stage. The ceiling value travels along with the candidate it was sampled with.

Top module: `adc_cost_unit`

## Requirements
- R1: While reset is asserted, and after its release until a candidate has passed through the pipeline, out_valid_o stays low.
- R2: A candidate sampled with in_valid_i high at rising edge n is presented with out_valid_o high after rising edge n+3 (four register stages). Any pattern of gaps is allowed, at a rate of up to one candidate per clock. out_valid_o is low in every cycle that no candidate occupies.
- R3: The intensity term equals floor(|ref - cand| * 256 / 255) for 8-bit pixels, which gives 256 for the largest difference. It is the same whichever of the two pixels is larger.
- R4: The census term equals floor(H * 256 / 80), where H is the number of bit positions in which the two 80-bit signatures differ. It is 256 when all the bits differ.
- R5: cost_o is the smaller of (intensity term + census term) and the ceiling. It is an unsigned 10-bit value with 8 fractional bits, where 256 stands for 1.0, so the unclamped sum is at most 512. A ceiling equal to the sum, or above it, leaves the sum unchanged.
- R6: The first candidate accepted after reset is tagged index 0. Each later accepted candidate is tagged with the next index, and the index returns to 0 after 53, giving 54 disparities per reference pixel. last_o is high exactly when the index is 53.
- R7: The ceiling is sampled together with each candidate. A new value affects only candidates sampled with it, and any value present while in_valid_i is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A candidate is present this cycle |
| ref_pix_i | input | 8 | Intensity of the reference pixel |
| cand_pix_i | input | 8 | Intensity of the candidate pixel |
| ref_cen_i | input | 80 | Census signature of the reference pixel |
| cand_cen_i | input | 80 | Census signature of the candidate pixel |
| trunc_i | input | 10 | Ceiling for the cost, 8 fractional bits |
| out_valid_o | output | 1 | Cost outputs carry a candidate |
| cost_o | output | 10 | Clamped fused cost, 8 fractional bits |
| disp_o | output | 6 | Disparity index of the candidate, 0 to 53 |
| last_o | output | 1 | Candidate is the final disparity of its group |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, 80-bit signatures, 54 disparities, 8 fractional bits and groups of 6 bits in the bit counter. These values make every intensity difference from 0 to 255 reachable. They also make every Hamming distance from 0 to 80 reachable, including the exact full-scale results of 256 on both terms. With 54 disparities, the index wrap occurs several times within a run of a few hundred candidates. Ceilings below, equal to and above the sum are applied, and the ceiling is changed between candidates and during idle cycles, so the sampling point of the ceiling is exercised along with the gap handling of the valid pipeline.

// File: rtl/adc_pkg.sv
package adc_pkg;

   // Register stages from input sample to output register.
   localparam int ADC_LATENCY = 4;

   // Multiplier that replaces a division by d: ceil(2^sh / d).
   function automatic longint unsigned recip_mult(input int sh, input int d);
      longint unsigned p;
      longint unsigned dd;
      p  = 64'd1 << sh;
      dd = longint'(d);
      return (p + dd - 64'd1) / dd;
   endfunction

endpackage

// File: rtl/adc_scale.sv
// Normalizes x to x / MAXV in fixed point with FRAC_W fractional bits,
// rounding down. A reciprocal multiply replaces the divider; the
// shift is chosen so that the result is exact for every input value.
module adc_scale #(
   parameter int IN_W   = 8,
   parameter int MAXV   = 255,
   parameter int FRAC_W = 8
) (
   input  logic [IN_W-1:0]   x_i,
   output logic [FRAC_W:0]   y_o
);
   localparam int NUM_W = IN_W + FRAC_W;
   localparam int SH    = NUM_W + $clog2(MAXV) + 1;
   localparam int PRD_W = NUM_W + SH + 1;
   localparam longint unsigned MULT = adc_pkg::recip_mult(SH, MAXV);

   if (SH > 62) begin : g_bad_shift
      $error("adc_scale: reciprocal shift %0d exceeds 62 bits", SH);
   end
   if (MAXV < 1) begin : g_bad_max
      $error("adc_scale: MAXV must be positive");
   end

   logic [NUM_W-1:0] num;
   logic [PRD_W-1:0] prod;

   always_comb begin
      num  = {x_i, {FRAC_W{1'b0}}};
      prod = PRD_W'(num) * PRD_W'(MULT);
      y_o  = (FRAC_W+1)'(prod >> SH);
   end
endmodule

// File: rtl/adc_hamming.sv
// Two-stage Hamming distance. Stage 1 counts the disagreeing bits of
// each group of GRP_W bits into a small unary-to-binary count; stage 2
// adds the group counts.
module adc_hamming #(
   parameter int CEN_W = 80,
   parameter int GRP_W = 6
) (
   input  logic                       clk,
   input  logic [CEN_W-1:0]           a_i,
   input  logic [CEN_W-1:0]           b_i,
   output logic [$clog2(CEN_W+1)-1:0] ham_o
);
   localparam int NGRP  = (CEN_W + GRP_W - 1) / GRP_W;
   localparam int PAD_W = NGRP * GRP_W;
   localparam int CNT_W = $clog2(GRP_W + 1);
   localparam int HAM_W = $clog2(CEN_W + 1);

   logic [PAD_W-1:0] diff;
   logic [CNT_W-1:0] grp_q [NGRP];
   logic [HAM_W-1:0] total;

   assign diff = PAD_W'(a_i ^ b_i);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [CNT_W-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int b = 0; b < GRP_W; b++) begin
            cnt = cnt + CNT_W'(diff[g*GRP_W + b]);
         end
      end
      always_ff @(posedge clk) begin
         grp_q[g] <= cnt;
      end
   end

   always_comb begin
      total = '0;
      for (int g = 0; g < NGRP; g++) begin
         total = total + HAM_W'(grp_q[g]);
      end
   end

   always_ff @(posedge clk) begin
      ham_o <= total;
   end
endmodule

// File: rtl/adc_disp_tag.sv
// Assigns each accepted candidate its position in the disparity group.
module adc_disp_tag #(
   parameter int NUM_DISP = 54
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv_i,
   output logic [$clog2(NUM_DISP)-1:0] idx_o,
   output logic                        last_o
);
   localparam int DISP_W = $clog2(NUM_DISP);
   localparam logic [DISP_W-1:0] TOP = DISP_W'(NUM_DISP - 1);

   logic [DISP_W-1:0] cnt_q;

   assign idx_o  = cnt_q;
   assign last_o = (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/adc_cost_unit.sv
module adc_cost_unit #(
   parameter int PIX_W    = 8,
   parameter int CEN_W    = 80,
   parameter int NUM_DISP = 54,
   parameter int FRAC_W   = 8,
   parameter int GRP_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid_i,
   input  logic [PIX_W-1:0]            ref_pix_i,
   input  logic [PIX_W-1:0]            cand_pix_i,
   input  logic [CEN_W-1:0]            ref_cen_i,
   input  logic [CEN_W-1:0]            cand_cen_i,
   input  logic [FRAC_W+1:0]           trunc_i,
   output logic                        out_valid_o,
   output logic [FRAC_W+1:0]           cost_o,
   output logic [$clog2(NUM_DISP)-1:0] disp_o,
   output logic                        last_o
);
   localparam int LAT    = adc_pkg::ADC_LATENCY;
   localparam int HAM_W  = $clog2(CEN_W + 1);
   localparam int TERM_W = FRAC_W + 1;
   localparam int COST_W = FRAC_W + 2;
   localparam int DISP_W = $clog2(NUM_DISP);
   localparam int PIX_MX = (1 << PIX_W) - 1;
   localparam int TR_DEP = LAT - 1;

   // elaboration-time parameter checks
   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
      $error("adc_cost_unit: PIX_W out of range");
   end
   if (CEN_W < 2) begin : g_bad_cen
      $error("adc_cost_unit: CEN_W must be at least 2");
   end
   if (NUM_DISP < 2) begin : g_bad_disp
      $error("adc_cost_unit: NUM_DISP must be at least 2");
   end
   if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
      $error("adc_cost_unit: FRAC_W out of range");
   end
   if (GRP_W < 2 || GRP_W > 8) begin : g_bad_grp
      $error("adc_cost_unit: GRP_W out of range");
   end

   // ---------------- control pipeline ----------------
   logic [DISP_W-1:0] tag_idx;
   logic              tag_last;
   logic [LAT-1:0]    v_q;
   logic [DISP_W-1:0] disp_q [LAT];
   logic              last_q [LAT];
   logic [COST_W-1:0] trunc_q [TR_DEP];

   adc_disp_tag #(.NUM_DISP(NUM_DISP)) i_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (in_valid_i),
      .idx_o  (tag_idx),
      .last_o (tag_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q <= {v_q[LAT-2:0], in_valid_i};
      end
   end

   always_ff @(posedge clk) begin
      disp_q[0]  <= tag_idx;
      last_q[0]  <= tag_last;
      trunc_q[0] <= trunc_i;
   end

   for (genvar s = 1; s < LAT; s++) begin : g_tag_pipe
      always_ff @(posedge clk) begin
         disp_q[s] <= disp_q[s-1];
         last_q[s] <= last_q[s-1];
      end
   end

   for (genvar s = 1; s < TR_DEP; s++) begin : g_trunc_pipe
      always_ff @(posedge clk) begin
         trunc_q[s] <= trunc_q[s-1];
      end
   end

   // ---------------- intensity path ----------------
   logic [PIX_W-1:0]  absd1_q;
   logic [TERM_W-1:0] ad_norm;
   logic [TERM_W-1:0] ad2_q;

   always_ff @(posedge clk) begin
      absd1_q <= (ref_pix_i > cand_pix_i) ? (ref_pix_i - cand_pix_i)
                                          : (cand_pix_i - ref_pix_i);
   end

   adc_scale #(.IN_W(PIX_W), .MAXV(PIX_MX), .FRAC_W(FRAC_W)) i_ad_scale (
      .x_i (absd1_q),
      .y_o (ad_norm)
   );

   always_ff @(posedge clk) begin
      ad2_q <= ad_norm;
   end

   // ---------------- census path ----------------
   logic [HAM_W-1:0]  ham2;
   logic [TERM_W-1:0] cen_norm;

   adc_hamming #(.CEN_W(CEN_W), .GRP_W(GRP_W)) i_ham (
      .clk   (clk),
      .a_i   (ref_cen_i),
      .b_i   (cand_cen_i),
      .ham_o (ham2)
   );

   adc_scale #(.IN_W(HAM_W), .MAXV(CEN_W), .FRAC_W(FRAC_W)) i_cen_scale (
      .x_i (ham2),
      .y_o (cen_norm)
   );

   // ---------------- fuse and clamp ----------------
   logic [COST_W-1:0] sum3_q;
   logic [COST_W-1:0] cost4_q;

   always_ff @(posedge clk) begin
      sum3_q  <= COST_W'(ad2_q) + COST_W'(cen_norm);
      cost4_q <= (sum3_q > trunc_q[TR_DEP-1]) ? trunc_q[TR_DEP-1] : sum3_q;
   end

   assign out_valid_o = v_q[LAT-1];
   assign cost_o      = cost4_q;
   assign disp_o      = disp_q[LAT-1];
   assign last_o      = last_q[LAT-1];
endmodule

// File: rtl/adc_cost_unit_chk.sv
module adc_cost_unit_chk #(
   parameter int NUM_DISP = 54,
   parameter int FRAC_W   = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid_i,
   input logic                        out_valid_o,
   input logic [FRAC_W+1:0]           cost_o,
   input logic [$clog2(NUM_DISP)-1:0] disp_o,
   input logic                        last_o
);
   localparam int DISP_W = $clog2(NUM_DISP);
   localparam logic [DISP_W-1:0] TOP = DISP_W'(NUM_DISP - 1);
   localparam logic [FRAC_W+1:0] CMAX = (FRAC_W+2)'(2 << FRAC_W);

   logic [2:0]        since_rst;
   logic              seen_q;
   logic [DISP_W-1:0] next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         seen_q    <= 1'b0;
         next_q    <= '0;
      end else begin
         if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
         if (out_valid_o) begin
            seen_q <= 1'b1;
            next_q <= (disp_o == TOP) ? '0 : disp_o + 1'b1;
         end
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 3'd4) |-> !out_valid_o); // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4) |-> (out_valid_o == $past(in_valid_i, 4))); // R2
   AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (cost_o <= CMAX)); // R5
   AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (disp_o <= TOP)); // R6
   AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (last_o == (disp_o == TOP))); // R6
   AST_DISP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && seen_q) |-> (disp_o == next_q)); // R6
   AST_DISP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !seen_q) |-> (disp_o == '0)); // R6
endmodule

bind adc_cost_unit adc_cost_unit_chk #(
   .NUM_DISP (NUM_DISP),
   .FRAC_W   (FRAC_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid_i  (in_valid_i),
   .out_valid_o (out_valid_o),
   .cost_o      (cost_o),
   .disp_o      (disp_o),
   .last_o      (last_o)
);

// File: tb/test_adc_cost_unit.sv
module test_adc_cost_unit;
   localparam int ND   = 54;
   localparam int CW   = 80;
   localparam int FR   = 8;
   localparam int ONE  = 1 << FR;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid_i = 1'b0;
   logic [7:0]    ref_pix_i = '0;
   logic [7:0]    cand_pix_i = '0;
   logic [CW-1:0] ref_cen_i = '0;
   logic [CW-1:0] cand_cen_i = '0;
   logic [9:0]    trunc_i = '0;
   logic          out_valid_o;
   logic [9:0]    cost_o;
   logic [5:0]    disp_o;
   logic          last_o;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R5";

   always #4 clk = ~clk;

   adc_cost_unit i_adc_cost_unit (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
      .ref_pix_i(ref_pix_i), .cand_pix_i(cand_pix_i),
      .ref_cen_i(ref_cen_i), .cand_cen_i(cand_cen_i), .trunc_i(trunc_i),
      .out_valid_o(out_valid_o), .cost_o(cost_o), .disp_o(disp_o),
      .last_o(last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_cost(input int a, input int b,
                                     input logic [CW-1:0] ca, input logic [CW-1:0] cb,
                                     input int tr);
      int ad, adn, h, hn, s;
      ad  = (a > b) ? a - b : b - a;
      adn = (ad * ONE) / 255;
      h   = $countones(ca ^ cb);
      hn  = (h * ONE) / CW;
      s   = adn + hn;
      return (s > tr) ? tr : s;
   endfunction

   // behavioural model: four-deep delay of expected results
   bit    ev [4];
   int    ec [4];
   int    ed [4];
   bit    el [4];
   string er [4];
   int    m_disp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) ev[i] <= 1'b0;
         m_disp <= 0;
      end else begin
         for (int i = 3; i > 0; i--) begin
            ev[i] <= ev[i-1]; ec[i] <= ec[i-1]; ed[i] <= ed[i-1];
            el[i] <= el[i-1]; er[i] <= er[i-1];
         end
         ev[0] <= in_valid_i;
         ec[0] <= model_cost(int'(ref_pix_i), int'(cand_pix_i), ref_cen_i,
                             cand_cen_i, int'(trunc_i));
         ed[0] <= m_disp;
         el[0] <= (m_disp == ND - 1);
         er[0] <= cur_req;
         if (in_valid_i) m_disp <= (m_disp == ND - 1) ? 0 : m_disp + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(out_valid_o == ev[3], "R2", int'(out_valid_o), int'(ev[3]));
         if (out_valid_o && ev[3]) begin
            chk(int'(cost_o) == ec[3], er[3], int'(cost_o), ec[3]);
            chk(int'(disp_o) == ed[3], "R6 index", int'(disp_o), ed[3]);
            chk(last_o == el[3], "R6 last", int'(last_o), int'(el[3]));
         end
      end
   end

   function automatic logic [CW-1:0] rnd_cen();
      return CW'({$urandom, $urandom, $urandom});
   endfunction

   function automatic logic [CW-1:0] flip_bits(input logic [CW-1:0] c, input int k);
      logic [CW-1:0] r;
      r = c;
      for (int i = 0; i < k; i++) r[(i * 7) % CW] = ~r[(i * 7) % CW];
      return r;
   endfunction

   task automatic send(input int a, input int b, input logic [CW-1:0] ca,
                       input logic [CW-1:0] cb, input int tr, input string req);
      @(negedge clk);
      in_valid_i = 1'b1;
      ref_pix_i  = 8'(a);
      cand_pix_i = 8'(b);
      ref_cen_i  = ca;
      cand_cen_i = cb;
      trunc_i    = 10'(tr);
      cur_req    = req;
   endtask

   task automatic idle(input int n, input int tr);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid_i = 1'b0;
         trunc_i    = 10'(tr);
         ref_pix_i  = 8'($urandom);
         cand_pix_i = 8'($urandom);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [CW-1:0] c;
      // R1: quiet during and just after reset
      repeat (3) @(negedge clk);
      chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
      end

      // R3: intensity term alone (equal signatures, no clamp)
      c = rnd_cen();
      send(255, 0, c, c, 1023, "R3");
      send(0, 255, c, c, 1023, "R3");
      send(254, 0, c, c, 1023, "R3");
      send(7, 8, c, c, 1023, "R3");
      send(90, 90, c, c, 1023, "R3");
      for (int i = 0; i < 20; i++) begin
         c = rnd_cen();
         send(int'($urandom % 256), int'($urandom % 256), c, c, 1023, "R3");
      end

      // R4: census term alone (equal pixels)
      c = rnd_cen();
      send(40, 40, c, ~c, 1023, "R4");
      send(40, 40, c, flip_bits(c, 1), 1023, "R4");
      send(40, 40, c, flip_bits(c, 5), 1023, "R4");
      send(40, 40, c, flip_bits(c, 79), 1023, "R4");
      for (int k = 0; k <= CW; k += 9) begin
         c = rnd_cen();
         send(17, 17, c, flip_bits(c, k), 1023, "R4");
      end

      // R5: fused sum and clamp corners
      c = rnd_cen();
      send(0, 255, c, ~c, 1023, "R5");
      send(0, 255, c, ~c, 512, "R5");
      send(0, 255, c, ~c, 511, "R5");
      send(0, 255, c, ~c, 300, "R5");
      send(0, 255, c, ~c, 0, "R5");
      send(12, 12, c, c, 0, "R5");
      for (int i = 0; i < 30; i++) begin
         send(int'($urandom % 256), int'($urandom % 256), rnd_cen(), rnd_cen(),
              1023, "R5");
      end

      // R7 and R2: ceiling changes per candidate and while idle, random gaps
      for (int i = 0; i < 200; i++) begin
         send(int'($urandom % 256), int'($urandom % 256), rnd_cen(), rnd_cen(),
              int'($urandom % 600), "R7");
         if ($urandom % 3 == 0) idle(int'($urandom % 4) + 1, int'($urandom % 1024));
      end

      // R6: long back-to-back run across several wraps
      for (int i = 0; i < 3 * ND; i++) begin
         send(int'($urandom % 256), int'($urandom % 256), rnd_cen(), rnd_cen(),
              int'($urandom % 1024), "R6");
      end

      idle(8, 0);
      summary();
      $finish;
   end
endmodule